// File: doc/BRIEF.md
# Split Six-Position Up/Down Sequencer

This block steps through six positions in a ring, forward on an up request and backward on a down request. It is not built as one flat six-state machine. Two four-state machines share the work. The low machine owns positions 0, 1 and 2 plus a parking state. The high machine owns positions 3, 4 and 5 plus its own parking state.

Exactly one machine is active at any time, and the other waits in its parking state. A step that would leave the active machine's range sends that machine to its parking state. In the same cycle, the parked machine wakes into the matching position.

Each parking state stays put until one of its wake-up conditions occurs. The hold condition is the complement of the OR of those wake-up conditions. The ring position is decoded from the two small state registers. Both raw registers are also exposed so that the handoff can be observed.

Top module: `updn_split_seq`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it is released, the low machine holds code 0 (position 0) and the high machine holds code 3 (parked). The position output reads 0.
- R2: State encoding:
  - The low machine uses code 0 for position 0, code 1 for position 1, code 2 for position 2 and code 3 for parked.
  - The high machine uses code 0 for position 3, code 1 for position 4, code 2 for position 5 and code 3 for parked.
  - The position output equals the low code when the low machine is not parked, and 3 plus the high code otherwise.
- R3: A cycle with up high and down low advances the position by one at the next clock edge, with 5 wrapping to 0.
- R4: A cycle with down high and up low moves the position back by one at the next clock edge, with 0 wrapping to 5.
- R5: A cycle with up and down both low, or both high, leaves both state registers unchanged.
- R6: In every cycle, exactly one of the two machines is parked.
- R7: An up step from position 2 parks the low machine and wakes the high machine into position 3 in the same edge. An up step from position 5 parks the high machine and wakes the low machine into position 0.
- R8: A down step from position 3 parks the high machine and wakes the low machine into position 2 in the same edge. A down step from position 0 parks the low machine and wakes the high machine into position 5.
- R9: Only 6 of the 16 combinations of the two state registers ever occur: (0,3), (1,3), (2,3), (3,0), (3,1) and (3,2), written as (low code, high code).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| up_i | input | 1 | Step-up request |
| dn_i | input | 1 | Step-down request |
| pos_o | output | 3 | Decoded ring position, 0 to 5 |
| lo_st_o | output | 2 | Low machine state code |
| hi_st_o | output | 2 | High machine state code |

## Verification
A wrong internal state shows up at the ports one edge after the faulty transition. If both machines end up parked or both end up active, the state pair leaves the six legal combinations at once. If a handoff is missed, the position output stays stuck or jumps, and every later step diverges from a flat modulo-6 counter. For that reason the full state pair and the position are compared against the flat model after every edge, so a single bad transition is reported in the cycle it occurs.

// File: rtl/updn_split_seq.sv
module updn_split_seq #(
  parameter int unsigned SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_i,
  input  logic          dn_i,
  output logic [2:0]    pos_o,
  output logic [SW-1:0] lo_st_o,
  output logic [SW-1:0] hi_st_o
);

  localparam logic [SW-1:0] C0   = SW'(0);
  localparam logic [SW-1:0] C1   = SW'(1);
  localparam logic [SW-1:0] C2   = SW'(2);
  localparam logic [SW-1:0] PARK = SW'(3);

  logic [SW-1:0] lo_q, lo_d, hi_q, hi_d;
  logic up, dn;
  logic lo_wake_up, lo_wake_dn, hi_wake_up, hi_wake_dn;

  assign up = up_i & ~dn_i;
  assign dn = dn_i & ~up_i;

  assign lo_wake_up = up & (hi_q == C2);
  assign lo_wake_dn = dn & (hi_q == C0);
  assign hi_wake_up = up & (lo_q == C2);
  assign hi_wake_dn = dn & (lo_q == C0);

  always_comb begin
    lo_d = lo_q;
    case (lo_q)
      C0:      if (up) lo_d = C1; else if (dn) lo_d = PARK;
      C1:      if (up) lo_d = C2; else if (dn) lo_d = C0;
      C2:      if (up) lo_d = PARK; else if (dn) lo_d = C1;
      default: if (lo_wake_up) lo_d = C0;
               else if (lo_wake_dn) lo_d = C2;
               else lo_d = PARK;
    endcase
  end

  always_comb begin
    hi_d = hi_q;
    case (hi_q)
      C0:      if (up) hi_d = C1; else if (dn) hi_d = PARK;
      C1:      if (up) hi_d = C2; else if (dn) hi_d = C0;
      C2:      if (up) hi_d = PARK; else if (dn) hi_d = C1;
      default: if (hi_wake_up) hi_d = C0;
               else if (hi_wake_dn) hi_d = C2;
               else hi_d = PARK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= C0;
      hi_q <= PARK;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_st_o = lo_q;
  assign hi_st_o = hi_q;
  assign pos_o   = (lo_q != PARK) ? 3'(lo_q) : 3'(hi_q) + 3'd3;

  AST_ONE_PARKED: assert property (@(posedge clk) disable iff (rst)
    (lo_q == PARK) != (hi_q == PARK)) else $error("one parked"); // R6

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos_o <= 3'd5) else $error("pos range"); // R9

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (up_i && !dn_i) |=> pos_o == (($past(pos_o) == 3'd5) ? 3'd0 : $past(pos_o) + 3'd1))
    else $error("up step"); // R3

  AST_DN_STEP: assert property (@(posedge clk) disable iff (rst)
    (dn_i && !up_i) |=> pos_o == (($past(pos_o) == 3'd0) ? 3'd5 : $past(pos_o) - 3'd1))
    else $error("down step"); // R4

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (up_i == dn_i) |=> ($stable(lo_st_o) && $stable(hi_st_o))) else $error("hold"); // R5

  AST_HANDOFF_UP: assert property (@(posedge clk) disable iff (rst)
    (up_i && !dn_i && lo_st_o == C2) |=> (lo_st_o == PARK && hi_st_o == C0))
    else $error("handoff up"); // R7

  AST_HANDOFF_DN: assert property (@(posedge clk) disable iff (rst)
    (dn_i && !up_i && hi_st_o == C0) |=> (hi_st_o == PARK && lo_st_o == C2))
    else $error("handoff down"); // R8

endmodule

// File: tb/sim_updn_split_seq.sv
`timescale 1ns/100ps
module sim_updn_split_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_i = 1'b0, dn_i = 1'b0;
  logic [2:0] pos_o;
  logic [1:0] lo_st_o, hi_st_o;
  int total = 0, bad = 0;
  int model = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  updn_split_seq u0 (.clk(clk), .rst(rst), .up_i(up_i), .dn_i(dn_i),
                     .pos_o(pos_o), .lo_st_o(lo_st_o), .hi_st_o(hi_st_o));

  function automatic int step_of(int p, bit u, bit d);
    if (u && !d) return (p == 5) ? 0 : p + 1;
    if (d && !u) return (p == 0) ? 5 : p - 1;
    return p;
  endfunction
  function automatic int lo_exp(int p); return (p < 3) ? p : 3; endfunction
  function automatic int hi_exp(int p); return (p >= 3) ? p - 3 : 3; endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " pos"}, int'(pos_o), model);
    chk({tag, " lo R2"}, int'(lo_st_o), lo_exp(model));
    chk({tag, " hi R2"}, int'(hi_st_o), hi_exp(model));
    chk("R6 one parked", int'((lo_st_o == 2'd3) ^ (hi_st_o == 2'd3)), 1);
  endtask

  task automatic step(bit u, bit d);
    int prev;
    string tag;
    @(negedge clk);
    up_i = u; dn_i = d;
    prev = model;
    @(posedge clk);
    model = step_of(model, u, d);
    #1;
    if (u == d) tag = "R5";
    else if (u && (prev == 2 || prev == 5)) tag = "R7";
    else if (d && (prev == 3 || prev == 0)) tag = "R8";
    else if (u) tag = "R3";
    else tag = "R4";
    check_all(tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    model = 0;
    check_all("R1 reset");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check_all("R1 released");
    for (int i = 0; i < 7; i++) step(1, 0);
    for (int i = 0; i < 8; i++) step(0, 1);
    step(0, 0); step(1, 1);
    for (int i = 0; i < 3; i++) step(1, 0);
    step(1, 1); step(0, 0);
    step(0, 1); step(1, 0); step(0, 1);
    void'($urandom(32'd1234));
    for (int i = 0; i < 2000; i++) begin
      int r = $urandom % 8;
      step(r < 3 || r == 7, (r >= 3 && r < 6) || r == 7);
    end
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    model = 0;
    check_all("R1 re-reset");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule